// File: doc/BRIEF.md
# Privilege-Masked Authority Register File

This unit keeps three 64-bit special-purpose registers: an authority mask (the main register), a user override mask and a supervisor override mask. Software reaches them through one register-access port that carries a register number, read and write strobes and write data. Two privilege inputs, problem state and hypervisor, decide whether an access is legal. For a write they also decide which override mask limits the bits that may change.

A write never simply replaces a register. It inserts the new data under a mask: `new = (old & ~mask) | (data & mask)`. In problem state the user override mask limits writes to the authority mask. In supervisor state the supervisor override mask limits writes to both the authority mask and the user override mask. In hypervisor state a write is unmasked. Reads always return the stored value in full. Illegal accesses change nothing, read as zero and raise a one-cycle flag.

Top module: `authmask_regfile`

## Requirements
- R1: After a synchronous reset, all three registers hold zero and `illegal_o` is low.
- R2: Register numbers 13 (user alias) and 29 (privileged number) select the same authority-mask storage. A legal read through either number returns all 64 stored bits.
- R3: With problem state high, a write to number 13 changes only the bits set in the user override mask, following `new = (old & ~mask) | (data & mask)`.
- R4: With both privilege inputs low, a write to number 13 or 29 changes only the bits set in the supervisor override mask, using the same insertion rule.
- R5: With problem state low and hypervisor high, a write to the authority mask (13 or 29) or to the user override mask (157) replaces all 64 bits.
- R6: With both privilege inputs low, a write to the user override mask (157) changes only the bits set in the supervisor override mask.
- R7: With problem state high, number 29 and number 157 are illegal to read and to write. Only number 13 is reachable.
- R8: The supervisor override mask (number 349) is legal only when problem state is low and hypervisor is high. Any other access to it is illegal.
- R9: An illegal access, or an access to any other number, leaves every register unchanged and drives `rd_data_o` to zero in that cycle. `illegal_o` is then high in the following cycle only, once for each offending strobe cycle.
- R10: When problem state and hypervisor are both high, problem state decides both the access rights and the write mask.
- R11: A write takes effect at the clock edge that samples the strobe. `rd_data_o` is combinational from the current contents, so a read in the same cycle as a write returns the old value. `rd_data_o` is zero when no legal read is strobed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| reg_num_i | input | 10 | Register number of the access |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 64 | Write data |
| prob_state_i | input | 1 | Problem (user) state |
| hyper_i | input | 1 | Hypervisor state |
| rd_data_o | output | 64 | Read data, combinational |
| illegal_o | output | 1 | One-cycle flag for an illegal or unknown access |

## Verification
The assertions assume that the privilege inputs and the register number stay steady for the whole cycle of a strobe. They also assume that a strobe is sampled at a single clock edge, so each insertion can be compared with the register and mask values of the cycle before. The stimulus drives every input on the falling edge and holds it across the next rising edge. It returns the strobes to idle before it reads a register back. Every read-back happens in hypervisor state, so the read-back itself can never be illegal.

// File: rtl/authmask_pkg.sv
package authmask_pkg;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_AMR   = 2'd1,
    SEL_UAMOR = 2'd2,
    SEL_AMOR  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MASK_ALL   = 2'd0,
    MASK_USER  = 2'd1,
    MASK_SUPER = 2'd2
  } mask_src_e;

  typedef struct packed {
    reg_sel_e  sel;
    logic      legal;
    mask_src_e mask_src;
  } access_t;

endpackage

// File: rtl/authmask_decode.sv
module authmask_decode
  import authmask_pkg::*;
#(
  parameter int NUM_W     = 10,
  parameter int USER_NUM  = 13,
  parameter int PRIV_NUM  = 29,
  parameter int UMASK_NUM = 157,
  parameter int SMASK_NUM = 349
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [NUM_W-1:0] reg_num_i,
  input  logic             prob_i,
  input  logic             hyper_i,
  output access_t          acc_o
);

  localparam logic [NUM_W-1:0] USER_N  = NUM_W'(USER_NUM);
  localparam logic [NUM_W-1:0] PRIV_N  = NUM_W'(PRIV_NUM);
  localparam logic [NUM_W-1:0] UMASK_N = NUM_W'(UMASK_NUM);
  localparam logic [NUM_W-1:0] SMASK_N = NUM_W'(SMASK_NUM);

  // Problem state outranks hypervisor: hypervisor only counts when PR is low.
  logic eff_hyper;
  assign eff_hyper = hyper_i & ~prob_i;

  reg_sel_e sel;
  always_comb begin
    if (reg_num_i == USER_N || reg_num_i == PRIV_N) sel = SEL_AMR;
    else if (reg_num_i == UMASK_N)                  sel = SEL_UAMOR;
    else if (reg_num_i == SMASK_N)                  sel = SEL_AMOR;
    else                                            sel = SEL_NONE;
  end

  logic legal;
  always_comb begin
    case (sel)
      SEL_AMR:   legal = ~prob_i | (reg_num_i == USER_N);
      SEL_UAMOR: legal = ~prob_i;
      SEL_AMOR:  legal = eff_hyper;
      default:   legal = 1'b0;
    endcase
  end

  mask_src_e msrc;
  always_comb begin
    if (prob_i)         msrc = MASK_USER;
    else if (eff_hyper) msrc = MASK_ALL;
    else                msrc = MASK_SUPER;
  end

  assign acc_o = '{sel: sel, legal: legal, mask_src: msrc};

  // R7: in problem state only the user alias number can be legal
  assert_user_only_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (prob_i && acc_o.legal) |-> (reg_num_i == USER_N));

  // R8: the supervisor mask is reachable in hypervisor state alone
  assert_smask_hv_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (reg_num_i == SMASK_N && acc_o.legal) |-> (hyper_i && !prob_i));

  // R10: both privilege bits high never opens privileged numbers
  assert_prob_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (prob_i && hyper_i && acc_o.legal) |-> (acc_o.sel == SEL_AMR));

endmodule

// File: rtl/authmask_insert.sv
module authmask_insert #(
  parameter int W = 64
) (
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] new_o
);

  // Bits under the mask take the data; the rest keep the old contents.
  assign new_o = (old_i & ~mask_i) | (data_i & mask_i);

endmodule

// File: rtl/authmask_regfile.sv
module authmask_regfile
  import authmask_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int NUM_W     = 10,
  parameter int USER_NUM  = 13,
  parameter int PRIV_NUM  = 29,
  parameter int UMASK_NUM = 157,
  parameter int SMASK_NUM = 349
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_W-1:0]  reg_num_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              prob_state_i,
  input  logic              hyper_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              illegal_o
);

  localparam int N_MASKED = 2;  // main register and user override mask
  localparam int IDX_AMR  = 0;
  localparam int IDX_UMR  = 1;

  access_t acc;

  authmask_decode #(
    .NUM_W    (NUM_W),
    .USER_NUM (USER_NUM),
    .PRIV_NUM (PRIV_NUM),
    .UMASK_NUM(UMASK_NUM),
    .SMASK_NUM(SMASK_NUM)
  ) u_decode (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .reg_num_i(reg_num_i),
    .prob_i   (prob_state_i),
    .hyper_i  (hyper_i),
    .acc_o    (acc)
  );

  logic [DATA_W-1:0] amr_q, umr_q, smr_q;

  logic [DATA_W-1:0] ins_mask;
  always_comb begin
    case (acc.mask_src)
      MASK_USER:  ins_mask = umr_q;
      MASK_SUPER: ins_mask = smr_q;
      default:    ins_mask = '1;
    endcase
  end

  logic [DATA_W-1:0] old_vec [N_MASKED];
  logic [DATA_W-1:0] new_vec [N_MASKED];
  assign old_vec[IDX_AMR] = amr_q;
  assign old_vec[IDX_UMR] = umr_q;

  for (genvar g = 0; g < N_MASKED; g++) begin : g_insert
    authmask_insert #(.W(DATA_W)) u_ins (
      .old_i (old_vec[g]),
      .data_i(wr_data_i),
      .mask_i(ins_mask),
      .new_o (new_vec[g])
    );
  end

  logic wr_ok, bad_access;
  assign wr_ok      = wr_en_i & acc.legal;
  assign bad_access = (rd_en_i | wr_en_i) & ~acc.legal;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      amr_q     <= '0;
      umr_q     <= '0;
      smr_q     <= '0;
      illegal_o <= 1'b0;
    end else begin
      illegal_o <= bad_access;
      if (wr_ok && acc.sel == SEL_AMR)   amr_q <= new_vec[IDX_AMR];
      if (wr_ok && acc.sel == SEL_UAMOR) umr_q <= new_vec[IDX_UMR];
      if (wr_ok && acc.sel == SEL_AMOR)  smr_q <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i && acc.legal) begin
      case (acc.sel)
        SEL_AMR:   rd_data_o = amr_q;
        SEL_UAMOR: rd_data_o = umr_q;
        SEL_AMOR:  rd_data_o = smr_q;
        default:   rd_data_o = '0;
      endcase
    end
  end

  // R1: the cycle after reset releases, every register is clear
  assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(rst_i) |-> (amr_q == '0 && umr_q == '0 && smr_q == '0 && !illegal_o));

  // R3: user-state write keeps every bit outside the user override mask
  assert_user_keep_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && prob_state_i && reg_num_i == NUM_W'(USER_NUM)) |=>
      (((amr_q ^ $past(amr_q)) & ~$past(umr_q)) == '0));

  // R4: supervisor write to the main register keeps bits outside its mask
  assert_super_keep_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !prob_state_i && !hyper_i) |=>
      (((amr_q ^ $past(amr_q)) & ~$past(smr_q)) == '0));

  // R6: supervisor write to the user override mask keeps bits outside its mask
  assert_umask_keep_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !prob_state_i && !hyper_i) |=>
      (((umr_q ^ $past(umr_q)) & ~$past(smr_q)) == '0));

  // R5: hypervisor write through the privileged number lands in full
  assert_hv_replace_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_en_i && !prob_state_i && hyper_i && reg_num_i == NUM_W'(PRIV_NUM)) |=>
      (amr_q == $past(wr_data_i)));

  // R9: a refused access leaves all storage untouched
  assert_refused_stable_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    bad_access |=> ($stable(amr_q) && $stable(umr_q) && $stable(smr_q)));

  // R9: the flag follows a strobe and never appears on its own
  assert_flag_pulse_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rd_en_i || wr_en_i) |=> !illegal_o);

endmodule

// File: tb/authmask_regfile_test.sv
module authmask_regfile_test;

  localparam int DW = 64;
  localparam int NW = 10;
  localparam logic [NW-1:0] N_USER  = 10'd13;
  localparam logic [NW-1:0] N_PRIV  = 10'd29;
  localparam logic [NW-1:0] N_UMASK = 10'd157;
  localparam logic [NW-1:0] N_SMASK = 10'd349;

  typedef struct packed {
    logic          pr;
    logic          hv;
    logic [NW-1:0] num;
    logic [DW-1:0] data;
    logic          ill;
    logic [NW-1:0] chk;
    logic [DW-1:0] exp;
    logic [7:0]    req;
  } vec_t;

  // Walked from reset in order; each row writes, then reads back chk in hypervisor state.
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, N_SMASK, 64'h00FF_00FF_00FF_00FF, 1'b0, N_SMASK, 64'h00FF_00FF_00FF_00FF, 8'd8},  // R8
    '{1'b0, 1'b1, N_UMASK, 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, N_UMASK, 64'h0F0F_0F0F_0F0F_0F0F, 8'd5},  // R5
    '{1'b0, 1'b1, N_PRIV,  64'h1234_5678_9ABC_DEF0, 1'b0, N_USER,  64'h1234_5678_9ABC_DEF0, 8'd2},  // R2
    '{1'b1, 1'b0, N_USER,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, N_PRIV,  64'h1F3F_5F7F_9FBF_DFFF, 8'd3},  // R3
    '{1'b0, 1'b0, N_PRIV,  64'h0000_0000_0000_0000, 1'b0, N_PRIV,  64'h1F00_5F00_9F00_DF00, 8'd4},  // R4
    '{1'b0, 1'b0, N_USER,  64'hFFFF_FFFF_FFFF_FFFF, 1'b0, N_PRIV,  64'h1FFF_5FFF_9FFF_DFFF, 8'd4},  // R4
    '{1'b0, 1'b0, N_UMASK, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, N_UMASK, 64'h0FFF_0FFF_0FFF_0FFF, 8'd6},  // R6
    '{1'b0, 1'b0, N_SMASK, 64'h0000_0000_0000_0000, 1'b1, N_SMASK, 64'h00FF_00FF_00FF_00FF, 8'd8},  // R8
    '{1'b1, 1'b0, N_PRIV,  64'h0000_0000_0000_0000, 1'b1, N_PRIV,  64'h1FFF_5FFF_9FFF_DFFF, 8'd7},  // R7
    '{1'b1, 1'b0, N_UMASK, 64'h0000_0000_0000_0000, 1'b1, N_UMASK, 64'h0FFF_0FFF_0FFF_0FFF, 8'd7},  // R7
    '{1'b1, 1'b1, N_USER,  64'h0000_0000_0000_0000, 1'b0, N_PRIV,  64'h1000_5000_9000_D000, 8'd10}, // R10
    '{1'b1, 1'b1, N_SMASK, 64'h0000_0000_0000_0000, 1'b1, N_SMASK, 64'h00FF_00FF_00FF_00FF, 8'd10}, // R10
    '{1'b0, 1'b1, 10'd5,   64'hFFFF_FFFF_FFFF_FFFF, 1'b1, N_PRIV,  64'h1000_5000_9000_D000, 8'd9},  // R9
    '{1'b0, 1'b1, N_USER,  64'hDEAD_BEEF_0000_0001, 1'b0, N_PRIV,  64'hDEAD_BEEF_0000_0001, 8'd5}   // R5
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] num = '0;
  logic          rd = 1'b0, wr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          pr = 1'b0, hv = 1'b0;
  logic [DW-1:0] rdata;
  logic          ill;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  authmask_regfile uut (
    .clk_i       (clk),
    .rst_i       (rst),
    .reg_num_i   (num),
    .rd_en_i     (rd),
    .wr_en_i     (wr),
    .wr_data_i   (wdata),
    .prob_state_i(pr),
    .hyper_i     (hv),
    .rd_data_o   (rdata),
    .illegal_o   (ill)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd = 1'b0; wr = 1'b0; num = '0; wdata = '0; pr = 1'b0; hv = 1'b0;
  endtask

  // Hypervisor read-back: drive at a falling edge, sample 1 ns later.
  task automatic peek(input logic [NW-1:0] n, output logic [DW-1:0] v);
    @(negedge clk);
    pr = 1'b0; hv = 1'b1; wr = 1'b0; rd = 1'b1; num = n;
    #1 v = rdata;
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 illegal_o after reset", {63'd0, ill}, '0);
    peek(N_PRIV,  v); chk("R1 main reg reset",  v, '0);
    peek(N_UMASK, v); chk("R1 user mask reset", v, '0);
    peek(N_SMASK, v); chk("R1 super mask reset", v, '0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pr = VECS[i].pr; hv = VECS[i].hv; num = VECS[i].num;
      wdata = VECS[i].data; wr = 1'b1; rd = 1'b0;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d illegal_o", VECS[i].req, i), {63'd0, ill}, {63'd0, VECS[i].ill});
      pr = 1'b0; hv = 1'b1; wr = 1'b0; rd = 1'b1; num = VECS[i].chk;
      #1 chk($sformatf("R%0d vec%0d readback", VECS[i].req, i), rdata, VECS[i].exp);
    end
    @(negedge clk);
    idle();

    // R9: illegal read returns zero at once, flag pulses exactly one cycle
    @(negedge clk);
    pr = 1'b1; hv = 1'b0; rd = 1'b1; num = N_PRIV;
    #1 chk("R9 illegal read data zero", rdata, '0);
    @(negedge clk);
    idle();
    chk("R9 flag high after illegal read", {63'd0, ill}, 64'd1);
    @(negedge clk);
    chk("R9 flag drops after one cycle", {63'd0, ill}, '0);

    // R9: two back-to-back illegal strobes give a two-cycle flag
    pr = 1'b1; rd = 1'b1; num = N_UMASK;
    @(negedge clk);
    chk("R9 flag after first strobe", {63'd0, ill}, 64'd1);
    @(negedge clk);
    idle();
    chk("R9 flag after second strobe", {63'd0, ill}, 64'd1);
    @(negedge clk);
    chk("R9 flag clear after pair", {63'd0, ill}, '0);

    // R2: user-state read through the alias returns the full value
    pr = 1'b1; hv = 1'b0; rd = 1'b1; num = N_USER;
    #1 chk("R2 user alias full read", rdata, 64'hDEAD_BEEF_0000_0001);
    @(negedge clk);
    chk("R2 alias read is legal", {63'd0, ill}, '0);
    idle();

    // R11: read during write shows old value, new value next cycle
    @(negedge clk);
    pr = 1'b0; hv = 1'b1; rd = 1'b1; wr = 1'b1; num = N_PRIV; wdata = 64'h0123_4567_89AB_CDEF;
    #1 chk("R11 read-during-write old value", rdata, 64'hDEAD_BEEF_0000_0001);
    @(negedge clk);
    wr = 1'b0;
    #1 chk("R11 new value after edge", rdata, 64'h0123_4567_89AB_CDEF);
    rd = 1'b0;
    #1 chk("R11 no strobe reads zero", rdata, '0);
    @(negedge clk);
    idle();

    // R1: reset in mid-run clears everything
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    peek(N_PRIV,  v); chk("R1 main reg cleared by reset",  v, '0);
    peek(N_SMASK, v); chk("R1 super mask cleared by reset", v, '0);

    finish_run();
  end

endmodule